// File: doc/BRIEF.md
# I2C Master with Software Pin Override

This block is an I2C bus master with two ways of driving the bus. In hardware mode a small engine takes one command per byte. It generates the serial clock, START, repeated START and STOP conditions, shifts a byte out or in, and handles the acknowledge slot. In software mode the engine is cut off from the pads, and three control bits let software drive each open-drain line directly and bit-bang any protocol it likes.

The pads are open-drain. The block has two pull-low enables, `sclOe` and `sdaOe`, and receives the resolved line levels `sclIn` and `sdaIn`. A write-only control word sets the mode and the two software pull bits. A status word reports both line levels through a two-flop synchronizer, together with a missing-acknowledge flag. Each hardware command carries flags for START, STOP, read and NACK-on-last, plus a byte to send. A received byte is presented on `rxData` with a one-cycle `rxValid` strobe. The block acts only as a master. It never answers as a slave, does not arbitrate and does not wait for clock stretching.

Top module: `i2c_dual_master`

## Requirements
- R1: After reset both pad enables are 0 (lines released), `cmdReady` is 1, software mode is off and `statOut` is 0 while both lines are high.
- R2: Writing control bit 0 = 1 turns software mode on. While it is on, `cmdReady` is 0, a held `cmdValid` moves neither pad, and the pads follow only the software pull bits. While software mode is off, the software pull bits have no effect on the pads.
- R3: In software mode, control bit 1 = 1 pulls SCL low and control bit 2 = 1 pulls SDA low. A 0 releases the line. The pads change in the cycle after the write.
- R4: `statOut[0]` is 1 when the SCL line is low and `statOut[1]` is 1 when the SDA line is low, whatever pulls the line. A pin change is not yet visible one clock edge later and is visible after the second edge.
- R5: A write command produces a START on an idle bus, then 8 data bits MSB first. SDA is released in the ninth (acknowledge) clock.
- R6: A read command releases SDA for 8 clocks, shifts the byte in MSB first, presents it on `rxData` with `rxValid` high for one cycle, and drives the acknowledge slot low unless `cmdNack` is 1, in which case the slot is left high.
- R7: With `cmdStop` = 1 the byte is followed by STOP. With `cmdStop` = 0 the bus stays owned with SCL held low and no STOP. A following command with `cmdStart` = 1 then produces a repeated START without a STOP in between.
- R8: If the slave leaves SDA high in the acknowledge slot of a write, `statOut[2]` becomes 1 and a STOP is issued whatever `cmdStop` says. The flag clears when the next command is accepted.
- R9: Each SCL level in hardware mode lasts at least `divCfg`+1 clocks (`divCfg` ≥ 3). In hardware mode SDA changes while SCL is high only to form START or STOP.
- R10: A command with `cmdStart` = 0 on an owned bus continues the transfer with the next byte, so any number of bytes fits between START and STOP. On an idle bus a START is inserted anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | 3 | Control word: bit0 software mode, bit1 SCL pull, bit2 SDA pull |
| statOut | output | 3 | Status: bit0 SCL low, bit1 SDA low, bit2 missing acknowledge |
| divCfg | input | DIV_W | SCL phase length minus one, in clocks |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle and hardware mode active |
| cmdStart | input | 1 | Precede the byte with START or repeated START |
| cmdStop | input | 1 | Follow the byte with STOP |
| cmdRead | input | 1 | 1 = read a byte, 0 = write `cmdData` |
| cmdNack | input | 1 | On a read, leave the acknowledge slot high |
| cmdData | input | 8 | Byte to send |
| rxData | output | 8 | Last byte received |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| sclIn | input | 1 | Resolved SCL line level |
| sdaIn | input | 1 | Resolved SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
Two pairs of functions can meet. The first is a missing slave acknowledge that arrives on a byte whose command already asked for STOP. The table includes such a vector, and the bench requires exactly one STOP on the bus and the flag set. The second is a hardware command that is being offered while software takes the pins. The bench holds `cmdValid` high for many cycles in software mode, checks that the pads stay at the software values and that nothing is accepted, and then returns to hardware mode.

// File: rtl/i2c_dm_pkg.sv
`timescale 1ns/1ps
package i2c_dm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int CTL_W  = 3;
  localparam int CTL_SW = 0;
  localparam int CTL_SCL = 1;
  localparam int CTL_SDA = 2;
  localparam int LINES  = 2;
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BITLO, ST_BITHI, ST_STOP} phase_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic rxDone;
    logic ackSet;
    logic divRestart;
    logic sclLow;
    logic sdaLow;
    logic sdaFree;
  } strobe_t;
endpackage

// File: rtl/i2c_dm_datapath.sv
`timescale 1ns/1ps
module i2c_dm_datapath
  import i2c_dm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strb,
  input  logic               ctlWrEn,
  input  logic [CTL_W-1:0]   ctlWrData,
  input  logic [DIV_W-1:0]   divCfg,
  input  logic [BYTE_W-1:0]  cmdData,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               swMode,
  output logic               tick,
  output logic               txMsb,
  output logic               sdaHigh,
  output logic [BYTE_W-1:0]  rxData,
  output logic               rxValid,
  output logic [CTL_W-1:0]   statOut,
  output logic               sclOe,
  output logic               sdaOe
);
  logic swEn, swScl, swSda;
  logic hwSclQ, hwSdaQ;
  logic [DIV_W-1:0] divCnt;
  logic [BYTE_W-1:0] shiftReg, rxReg;
  logic rxValidQ, ackErrQ;
  logic [LINES-1:0] padLow, syncA, syncB;

  assign padLow = {~sdaIn, ~sclIn};

  // software pull bits and mode, gated onto the pads below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swEn  <= 1'b0;
      swScl <= 1'b0;
      swSda <= 1'b0;
    end else if (ctlWrEn) begin
      swEn  <= ctlWrData[CTL_SW];
      swScl <= ctlWrData[CTL_SCL];
      swSda <= ctlWrData[CTL_SDA];
    end
  end

  // hardware pad drive; SDA moves only while SCL is already low unless freed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hwSclQ <= 1'b0;
      hwSdaQ <= 1'b0;
    end else begin
      hwSclQ <= strb.sclLow;
      if (strb.sdaFree || hwSclQ) hwSdaQ <= strb.sdaLow;
    end
  end

  // phase divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else if (strb.divRestart || divCnt == '0) divCnt <= divCfg;
    else divCnt <= divCnt - 1'b1;
  end
  assign tick = (divCnt == '0);

  // line synchronizer, two stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padLow;
      syncB <= syncA;
    end
  end

  // byte shifter, receive register, acknowledge flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      rxReg    <= '0;
      rxValidQ <= 1'b0;
      ackErrQ  <= 1'b0;
    end else begin
      if (strb.load) shiftReg <= cmdData;
      else if (strb.shift) shiftReg <= {shiftReg[BYTE_W-2:0], ~syncB[LINE_SDA]};
      rxValidQ <= strb.rxDone;
      if (strb.rxDone) rxReg <= shiftReg;
      if (strb.load) ackErrQ <= 1'b0;
      else if (strb.ackSet) ackErrQ <= 1'b1;
    end
  end

  assign swMode  = swEn;
  assign txMsb   = shiftReg[BYTE_W-1];
  assign sdaHigh = ~syncB[LINE_SDA];
  assign rxData  = rxReg;
  assign rxValid = rxValidQ;
  assign statOut = {ackErrQ, syncB[LINE_SDA], syncB[LINE_SCL]};
  assign sclOe   = swEn ? swScl : hwSclQ;
  assign sdaOe   = swEn ? swSda : hwSdaQ;

  AST_SW_PINS_FOLLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctlWrEn && ctlWrData[CTL_SW]) |->
      (sclOe == $past(ctlWrData[CTL_SCL])) && (sdaOe == $past(ctlWrData[CTL_SDA]))); // R3
  AST_SW_BLOCKS_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    (swMode && $past(swMode) && !$past(ctlWrEn)) |-> ($stable(sclOe) && $stable(sdaOe))); // R2
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!swMode && $past(!swMode) && $past(!sclOe) && $past(!strb.sdaFree)) |-> $stable(sdaOe)); // R9
endmodule

// File: rtl/i2c_dm_control.sv
`timescale 1ns/1ps
module i2c_dm_control
  import i2c_dm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    swMode,
  input  logic    tick,
  input  logic    txMsb,
  input  logic    sdaHigh,
  input  logic    ackErr,
  input  logic    cmdValid,
  input  logic    cmdStart,
  input  logic    cmdStop,
  input  logic    cmdRead,
  input  logic    cmdNack,
  output logic    cmdReady,
  output strobe_t strb
);
  phase_e state;
  logic [1:0] step;
  logic [CNT_W-1:0] bitCnt;
  logic busHeld, rdQ, nackQ, stopQ;
  logic accept, lastBit, ackBad, dataLow;

  assign cmdReady = (state == ST_IDLE) && !swMode;
  assign accept   = cmdValid && cmdReady;
  assign lastBit  = (bitCnt == CNT_W'(BYTE_W));
  assign ackBad   = !rdQ && sdaHigh;
  assign dataLow  = lastBit ? (rdQ && !nackQ) : (!rdQ && !txMsb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      step    <= '0;
      bitCnt  <= '0;
      busHeld <= 1'b0;
      rdQ     <= 1'b0;
      nackQ   <= 1'b0;
      stopQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          rdQ    <= cmdRead;
          nackQ  <= cmdNack;
          stopQ  <= cmdStop;
          bitCnt <= '0;
          step   <= '0;
          state  <= (cmdStart || !busHeld) ? ST_START : ST_BITLO;
        end
        ST_START: if (tick) begin
          if (step == 2'd3) begin
            state   <= ST_BITLO;
            busHeld <= 1'b1;
          end else step <= step + 1'b1;
        end
        ST_BITLO: if (tick) state <= ST_BITHI;
        ST_BITHI: if (tick) begin
          if (!lastBit) begin
            bitCnt <= bitCnt + 1'b1;
            state  <= ST_BITLO;
          end else if (ackBad || stopQ) begin
            step  <= '0;
            state <= ST_STOP;
          end else state <= ST_IDLE;
        end
        ST_STOP: if (tick) begin
          if (step == 2'd2) begin
            state   <= ST_IDLE;
            busHeld <= 1'b0;
          end else step <= step + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.load       = accept;
    strb.divRestart = accept;
    case (state)
      ST_IDLE:  strb.sclLow = busHeld;
      ST_START: begin
        strb.sclLow  = (step == 2'd0) ? busHeld : (step == 2'd3);
        strb.sdaLow  = (step >= 2'd2);
        strb.sdaFree = (step == 2'd2);
      end
      ST_BITLO: begin
        strb.sclLow = 1'b1;
        strb.sdaLow = dataLow;
      end
      ST_BITHI: begin
        strb.sdaLow = dataLow;
        strb.shift  = tick && !lastBit;
        strb.rxDone = tick && lastBit && rdQ;
        strb.ackSet = tick && lastBit && ackBad;
      end
      ST_STOP: begin
        strb.sclLow  = (step == 2'd0);
        strb.sdaLow  = (step != 2'd2);
        strb.sdaFree = (step == 2'd2);
      end
      default: strb.sclLow = 1'b0;
    endcase
  end

  AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state) && $past(state) != ST_IDLE) |-> $past(tick)); // R9
  AST_NACK_FORCES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackErr) |-> (state == ST_STOP)); // R8
endmodule

// File: rtl/i2c_dual_master.sv
`timescale 1ns/1ps
module i2c_dual_master
  import i2c_dm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWrEn,
  input  logic [2:0]        ctlWrData,
  output logic [2:0]        statOut,
  input  logic [DIV_W-1:0]  divCfg,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdRead,
  input  logic              cmdNack,
  input  logic [7:0]        cmdData,
  output logic [7:0]        rxData,
  output logic              rxValid,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe
);
  strobe_t strb;
  logic swMode, tick, txMsb, sdaHigh;

  i2c_dm_control ctrl_i (
    .clk(clk), .rst_n(rst_n), .swMode(swMode), .tick(tick), .txMsb(txMsb),
    .sdaHigh(sdaHigh), .ackErr(statOut[2]), .cmdValid(cmdValid), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdRead(cmdRead), .cmdNack(cmdNack), .cmdReady(cmdReady),
    .strb(strb)
  );

  i2c_dm_datapath #(.DIV_W(DIV_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .divCfg(divCfg), .cmdData(cmdData), .sclIn(sclIn), .sdaIn(sdaIn),
    .swMode(swMode), .tick(tick), .txMsb(txMsb), .sdaHigh(sdaHigh),
    .rxData(rxData), .rxValid(rxValid), .statOut(statOut), .sclOe(sclOe), .sdaOe(sdaOe)
  );
endmodule

// File: tb/i2c_dual_master_tb_top.sv
`timescale 1ns/1ps
module i2c_dual_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIVV = 3;
  localparam int WATCHDOG = 150000;
  localparam int NVEC = 6;
  // {read, nack, slaveAck, expAckErr, data}
  localparam logic [11:0] VEC [NVEC] = '{12'h2A5, 12'h13C, 12'h896, 12'hC01, 12'h2FF, 12'h200};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctlWrEn = 1'b0;
  logic [2:0] ctlWrData = '0;
  logic [2:0] statOut;
  logic [7:0] divCfg = 8'(DIVV);
  logic cmdValid = 1'b0, cmdReady, cmdStart = 1'b0, cmdStop = 1'b0, cmdRead = 1'b0, cmdNack = 1'b0;
  logic [7:0] cmdData = '0, rxData;
  logic rxValid, sclIn, sdaIn, sclOe, sdaOe;
  logic extScl = 1'b0, extSda = 1'b0, slaveLow = 1'b0;
  logic slaveEn = 1'b0, slaveRead = 1'b0, slaveAck = 1'b1, slaveDone = 1'b0, hwMon = 1'b0;
  logic [7:0] slaveTx = '0, capByte = '0, rxGot = '0;
  logic [7:0] byteLog [16];
  logic ackLog [16];
  int testsRun = 0, testsFailed = 0;
  int startCnt = 0, stopCnt = 0, logCnt = 0, rxCnt = 0, bitIdx = 0;
  int phaseLen = 0, minPhase = 1000;
  logic prevScl = 1'b1, prevSda = 1'b1;

  assign sclIn = !(sclOe || extScl);
  assign sdaIn = !(sdaOe || slaveLow || extSda);

  i2c_dual_master dut_i (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .statOut(statOut),
    .divCfg(divCfg), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdRead(cmdRead), .cmdNack(cmdNack), .cmdData(cmdData),
    .rxData(rxData), .rxValid(rxValid), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rxValid) begin
    rxGot <= rxData;
    rxCnt <= rxCnt + 1;
  end

  // bus monitor and simple slave model
  always @(negedge clk) begin
    logic cs, cd;
    cs = sclIn;
    cd = sdaIn;
    if (prevScl && cs && prevSda && !cd) begin
      startCnt++; bitIdx = 0; slaveDone = 1'b0; slaveLow = 1'b0;
    end else if (prevScl && cs && !prevSda && cd) begin
      stopCnt++; bitIdx = 0;
    end else if (!prevScl && cs) begin
      if (bitIdx < 8) capByte = {capByte[6:0], cd};
      else begin
        byteLog[logCnt % 16] = capByte;
        ackLog[logCnt % 16] = !cd;
        logCnt++;
        if (slaveRead && cd) slaveDone = 1'b1;
      end
      bitIdx = (bitIdx == 8) ? 0 : bitIdx + 1;
    end else if (prevScl && !cs && slaveEn) begin
      if (slaveRead) slaveLow = (!slaveDone && bitIdx < 8) ? !slaveTx[7 - bitIdx] : 1'b0;
      else slaveLow = (bitIdx == 8) && slaveAck;
    end
    if (cs != prevScl) begin
      if (hwMon && phaseLen < minPhase) minPhase = phaseLen;
      phaseLen = 1;
    end else phaseLen++;
    prevScl = cs;
    prevSda = cd;
  end

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCtl(input logic [2:0] v);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic doCmd(input logic st, input logic sp, input logic rd, input logic nk, input logic [7:0] d);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdStart = st; cmdStop = sp; cmdRead = rd; cmdNack = nk; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!cmdReady) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int s0, p0, l0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sclOe", sclOe, 0);
    check("R1 sdaOe", sdaOe, 0);
    check("R1 cmdReady", cmdReady, 1);
    check("R1 statOut", statOut, 0);

    hwMon = 1'b1; slaveEn = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      slaveRead = VEC[i][11]; slaveAck = VEC[i][9]; slaveTx = VEC[i][7:0];
      s0 = startCnt; p0 = stopCnt; l0 = logCnt; r0 = rxCnt;
      doCmd(1'b1, 1'b1, VEC[i][11], VEC[i][10], VEC[i][7:0]);
      check("R5 one START", startCnt - s0, 1);
      check("R7 one STOP", stopCnt - p0, 1);
      if (!VEC[i][11]) begin
        check("R5 byte on bus", byteLog[l0 % 16], VEC[i][7:0]);
        check("R8 ack flag", statOut[2], VEC[i][8]);
      end else begin
        check("R6 rxValid count", rxCnt - r0, 1);
        check("R6 rxData", rxGot, VEC[i][7:0]);
        check("R6 master ack", ackLog[l0 % 16], !VEC[i][10]);
      end
    end

    // multi-byte with repeated START
    slaveRead = 1'b0; slaveAck = 1'b1;
    s0 = startCnt; p0 = stopCnt; l0 = logCnt;
    doCmd(1'b1, 1'b0, 1'b0, 1'b0, 8'hA2);
    check("R7 bus held SCL low", sclOe, 1);
    check("R7 no STOP yet", stopCnt - p0, 0);
    doCmd(1'b0, 1'b0, 1'b0, 1'b0, 8'h5B);
    check("R10 continued byte", byteLog[(l0 + 1) % 16], 8'h5B);
    check("R10 no extra START", startCnt - s0, 1);
    slaveRead = 1'b1; slaveTx = 8'hC3;
    doCmd(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    check("R7 repeated START", startCnt - s0, 2);
    check("R7 single STOP", stopCnt - p0, 1);
    check("R5 first byte", byteLog[l0 % 16], 8'hA2);
    check("R6 read after Sr", rxGot, 8'hC3);

    // missing ack without stop request
    slaveRead = 1'b0; slaveAck = 1'b0;
    p0 = stopCnt;
    doCmd(1'b1, 1'b0, 1'b0, 1'b0, 8'h4E);
    check("R8 forced STOP", stopCnt - p0, 1);
    check("R8 flag set", statOut[2], 1);
    check("R8 bus released", sclOe, 0);
    slaveAck = 1'b1; s0 = startCnt; l0 = logCnt;
    doCmd(1'b0, 1'b1, 1'b0, 1'b0, 8'h77);
    check("R10 START inserted", startCnt - s0, 1);
    check("R8 flag cleared", statOut[2], 0);
    check("R5 byte 77", byteLog[l0 % 16], 8'h77);
    check("R9 min SCL phase", (minPhase >= DIVV + 1) ? 1 : 0, 1);

    // software mode
    hwMon = 1'b0; slaveEn = 1'b0;
    wrCtl(3'b101);
    check("R3 SDA pulled", sdaOe, 1);
    check("R3 SCL released", sclOe, 0);
    check("R2 not ready", cmdReady, 0);
    @(negedge clk);
    check("R4 one edge old", statOut[1:0], 2'b00);
    @(negedge clk);
    check("R4 two edges new", statOut[1:0], 2'b10);
    wrCtl(3'b011);
    check("R3 SCL pulled", sclOe, 1);
    check("R3 SDA released", sdaOe, 0);
    repeat (2) @(negedge clk);
    check("R4 SCL low stat", statOut[1:0], 2'b01);
    wrCtl(3'b001);
    extSda = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 external pull", statOut[1:0], 2'b10);
    extSda = 1'b0;
    cmdValid = 1'b1; cmdStart = 1'b1; cmdStop = 1'b1; cmdRead = 1'b0; cmdData = 8'h00;
    repeat (40) @(negedge clk);
    check("R2 cmd ignored SCL", sclOe, 0);
    check("R2 cmd ignored SDA", sdaOe, 0);
    cmdValid = 1'b0;
    wrCtl(3'b000);
    check("R2 ready again", cmdReady, 1);
    wrCtl(3'b110);
    check("R2 pull bits ignored", {sclOe, sdaOe}, 2'b00);
    wrCtl(3'b000);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule